// File: doc/BRIEF.md
# SYSREF Capture Delay Calibration

This controller picks the delay tap for the SYSREF path so that SYSREF lands in the middle of its setup/hold window relative to the device clock. When started, it walks the delay setting through every tap in turn while SYSREF keeps running. At each tap it waits a programmable settle time and then fires one SYSREF request together with a clear of the device's dirty-capture status flag. After a fixed capture wait it reads that flag back. A set flag marks the tap as marginal, because setup or hold was violated there.

Across the sweep the controller keeps the longest run of consecutive clean taps. The dirty taps on either side of that run are the setup-failure and hold-failure boundaries. The controller then programs the tap halfway between the first and last clean tap of the run. If no tap is clean, it raises a fail flag and puts the tap back to the value it held before the sweep. A one-cycle done pulse closes every sweep. The delay element itself sits outside this block and only sees the tap output.

Top module: `sysref_delay_cal`

## Requirements
- R1: After reset, tapOut, resultTap, failFlag, done, sysrefReq and flagClr are all 0.
- R2: A sweep sets tapOut to 0, 1, … NUM_TAPS-1 in ascending order. Each tap gets exactly one sysrefReq, and tapOut stays unchanged from that request until the flag is sampled.
- R3: At each tap, tapOut first holds for settleCycles+1 cycles without a request. After that, sysrefReq and flagClr are high together for one cycle. settleCycles is latched when the start is accepted.
- R4: dirtyIn is sampled only in the CAPT_CYCLES-th cycle after the request cycle. Its value in every other cycle has no effect (1 = dirty, 0 = clean).
- R5: The result is the longest run of consecutive clean taps, with the earliest run winning a tie. resultTap = floor((first + last) / 2) of that run.
- R6: If no tap is clean, failFlag is 1, and both tapOut and resultTap return to the tapOut value from before the sweep.
- R7: When done is high, tapOut equals resultTap.
- R8: done is high for exactly one cycle, in the cycle NUM_TAPS*(settleCycles+2+CAPT_CYCLES)+2 after the cycle in which startReq is accepted. resultTap and failFlag change only together with done, and they hold until the next sweep.
- R9: startReq is ignored while a sweep is in progress. The sweep neither restarts nor lengthens.
- R10: If every tap is clean, resultTap = floor((NUM_TAPS-1)/2). A failFlag set by an earlier sweep is cleared by a successful one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device-side control clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startReq | input | 1 | Starts a sweep when idle |
| settleCycles | input | SETTLE_W | Settle count applied after every tap change |
| dirtyIn | input | 1 | Dirty-capture status flag from the converter (1 = marginal) |
| tapOut | output | TAP_W | Delay tap driven to the delay element |
| sysrefReq | output | 1 | One-cycle SYSREF request strobe |
| flagClr | output | 1 | One-cycle clear of the dirty-capture flag |
| done | output | 1 | One-cycle end-of-sweep pulse |
| resultTap | output | TAP_W | Chosen (or restored) tap |
| failFlag | output | 1 | No clean tap was found in the last sweep |

## Verification
The assertions check, on every cycle, the spacing between consecutive SYSREF requests against the latched settle count and the capture wait. They also check that the tap holds steady after each request, that done is a single-cycle pulse, that the result changes only together with done, and that the tap matches the result at done. The run-search arithmetic can only be shown by the bench's scenarios. Those scenarios cover a single window, two windows of unequal length, tied windows, an even-length window that needs rounding down, an all-clean sweep and an all-dirty sweep that restores the earlier tap. The bench's scenarios also cover the total sweep duration, a start pulse during a sweep, and junk on dirtyIn outside the sampling cycle.

// File: rtl/sysref_cal_pkg.sv
package sysref_cal_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_FIRE,
    ST_CAPT,
    ST_FINISH,
    ST_DONE
  } calState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic beginSweep;
    logic fire;
    logic sample;
    logic advance;
    logic finish;
  } calStrobe_t;

endpackage

// File: rtl/sysref_cal_ctrl.sv
module sysref_cal_ctrl
  import sysref_cal_pkg::*;
#(
  parameter int SETTLE_W    = 8,
  parameter int CAPT_CYCLES = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                startReq,
  input  logic [SETTLE_W-1:0] settleCycles,
  input  logic                lastTap,
  output calStrobe_t          strobe,
  output logic                done
);

  localparam int CAPT_W = $clog2(CAPT_CYCLES + 1);
  localparam int CNT_W  = (SETTLE_W > CAPT_W) ? SETTLE_W : CAPT_W;
  localparam logic [CNT_W-1:0] CAPT_LAST = CNT_W'(CAPT_CYCLES - 1);

  calState_t           state, stateNext;
  logic [CNT_W-1:0]    cnt;
  logic [SETTLE_W-1:0] settleLat;
  logic                settleEnd, captEnd;

  assign settleEnd = (cnt == CNT_W'(settleLat));
  assign captEnd   = (cnt == CAPT_LAST);

  always_comb begin
    stateNext = state;
    strobe    = '0;
    done      = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (startReq) begin
          strobe.beginSweep = 1'b1;
          stateNext         = ST_SETTLE;
        end
      end
      ST_SETTLE: if (settleEnd) stateNext = ST_FIRE;
      ST_FIRE: begin
        strobe.fire = 1'b1;
        stateNext   = ST_CAPT;
      end
      ST_CAPT: begin
        if (captEnd) begin
          strobe.sample = 1'b1;
          if (lastTap) begin
            stateNext = ST_FINISH;
          end else begin
            strobe.advance = 1'b1;
            stateNext      = ST_SETTLE;
          end
        end
      end
      ST_FINISH: begin
        strobe.finish = 1'b1;
        stateNext     = ST_DONE;
      end
      ST_DONE: begin
        done      = 1'b1;
        stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      settleLat <= '0;
    end else begin
      state <= stateNext;
      if (strobe.beginSweep) settleLat <= settleCycles;
      if (stateNext != state) cnt <= '0;
      else                    cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/sysref_cal_dp.sv
module sysref_cal_dp
  import sysref_cal_pkg::*;
#(
  parameter int TAP_W    = 5,
  parameter int NUM_TAPS = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  calStrobe_t       strobe,
  input  logic             dirtyIn,
  output logic [TAP_W-1:0] tapOut,
  output logic [TAP_W-1:0] resultTap,
  output logic             failFlag,
  output logic             lastTap
);

  localparam int LEN_W = TAP_W + 1;
  localparam int SUM_W = TAP_W + 2;
  localparam logic [TAP_W-1:0] LAST_IDX = TAP_W'(NUM_TAPS - 1);

  logic [TAP_W-1:0] savedTap;
  logic [TAP_W-1:0] runStart, bestStart;
  logic [LEN_W-1:0] runLen, bestLen;
  logic [TAP_W-1:0] newStart;
  logic [LEN_W-1:0] newLen;
  logic [SUM_W-1:0] edgeSum;
  logic [TAP_W-1:0] midTap;

  assign lastTap = (tapOut == LAST_IDX);

  // extend the current clean run or open a new one at this tap
  always_comb begin
    if (runLen != '0) begin
      newStart = runStart;
      newLen   = runLen + 1'b1;
    end else begin
      newStart = tapOut;
      newLen   = LEN_W'(1);
    end
  end

  // first + last, where last = start + len - 1
  assign edgeSum = (SUM_W'(bestStart) << 1) + SUM_W'(bestLen) - SUM_W'(1);
  assign midTap  = TAP_W'(edgeSum >> 1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tapOut    <= '0;
      savedTap  <= '0;
      runStart  <= '0;
      runLen    <= '0;
      bestStart <= '0;
      bestLen   <= '0;
      resultTap <= '0;
      failFlag  <= 1'b0;
    end else begin
      if (strobe.beginSweep) begin
        savedTap <= tapOut;
        tapOut   <= '0;
        runLen   <= '0;
        bestLen  <= '0;
      end
      if (strobe.sample) begin
        if (!dirtyIn) begin
          runStart <= newStart;
          runLen   <= newLen;
          if (newLen > bestLen) begin
            bestStart <= newStart;
            bestLen   <= newLen;
          end
        end else begin
          runLen <= '0;
        end
      end
      if (strobe.advance) tapOut <= tapOut + 1'b1;
      if (strobe.finish) begin
        if (bestLen == '0) begin
          failFlag  <= 1'b1;
          resultTap <= savedTap;
          tapOut    <= savedTap;
        end else begin
          failFlag  <= 1'b0;
          resultTap <= midTap;
          tapOut    <= midTap;
        end
      end
    end
  end

endmodule

// File: rtl/sysref_delay_cal.sv
module sysref_delay_cal
  import sysref_cal_pkg::*;
#(
  parameter int TAP_W       = 5,
  parameter int NUM_TAPS    = 32,
  parameter int SETTLE_W    = 8,
  parameter int CAPT_CYCLES = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                startReq,
  input  logic [SETTLE_W-1:0] settleCycles,
  input  logic                dirtyIn,
  output logic [TAP_W-1:0]    tapOut,
  output logic                sysrefReq,
  output logic                flagClr,
  output logic                done,
  output logic [TAP_W-1:0]    resultTap,
  output logic                failFlag
);

  calStrobe_t strobe;
  logic       lastTap;
  logic       sweepBegin;

  sysref_cal_ctrl #(
    .SETTLE_W   (SETTLE_W),
    .CAPT_CYCLES(CAPT_CYCLES)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .startReq    (startReq),
    .settleCycles(settleCycles),
    .lastTap     (lastTap),
    .strobe      (strobe),
    .done        (done)
  );

  sysref_cal_dp #(
    .TAP_W   (TAP_W),
    .NUM_TAPS(NUM_TAPS)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .dirtyIn  (dirtyIn),
    .tapOut   (tapOut),
    .resultTap(resultTap),
    .failFlag (failFlag),
    .lastTap  (lastTap)
  );

  assign sysrefReq  = strobe.fire;
  assign flagClr    = strobe.fire;
  assign sweepBegin = strobe.beginSweep;

endmodule

// File: rtl/sysref_cal_chk.sv
module sysref_cal_chk #(
  parameter int TAP_W       = 5,
  parameter int SETTLE_W    = 8,
  parameter int CAPT_CYCLES = 4
) (
  input logic                clk,
  input logic                rstN,
  input logic [SETTLE_W-1:0] settleCycles,
  input logic                sweepBegin,
  input logic                sysrefReq,
  input logic                done,
  input logic [TAP_W-1:0]    tapOut,
  input logic [TAP_W-1:0]    resultTap,
  input logic                failFlag
);

  logic [15:0]         gap;
  logic                fromFire;
  logic [SETTLE_W-1:0] settleSeen;
  logic [15:0]         gapWant;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gap        <= '0;
      fromFire   <= 1'b0;
      settleSeen <= '0;
    end else begin
      if (sweepBegin) begin
        gap        <= 16'd1;
        fromFire   <= 1'b0;
        settleSeen <= settleCycles;
      end else if (sysrefReq) begin
        gap      <= 16'd1;
        fromFire <= 1'b1;
      end else if (gap != 16'hFFFF) begin
        gap <= gap + 16'd1;
      end
    end
  end

  assign gapWant = fromFire ? 16'(settleSeen) + 16'(CAPT_CYCLES + 2)
                            : 16'(settleSeen) + 16'd2;

  // R3: request spacing follows settle count and capture wait
  a_r3_request_spacing: assert property (@(posedge clk) disable iff (!rstN)
    sysrefReq |-> gap == gapWant);

  // R2: tap holds after its request
  a_r2_tap_hold: assert property (@(posedge clk) disable iff (!rstN)
    sysrefReq |=> $stable(tapOut));

  // R8: done is a single-cycle pulse
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R8: result only moves together with done
  a_r8_result_hold: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(resultTap) |-> done);

  // R8: fail flag only moves together with done
  a_r8_fail_hold: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(failFlag) |-> done);

  // R7: tap equals result at done
  a_r7_tap_matches: assert property (@(posedge clk) disable iff (!rstN)
    done |-> tapOut == resultTap);

endmodule

bind sysref_delay_cal sysref_cal_chk #(
  .TAP_W      (TAP_W),
  .SETTLE_W   (SETTLE_W),
  .CAPT_CYCLES(CAPT_CYCLES)
) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .settleCycles(settleCycles),
  .sweepBegin  (sweepBegin),
  .sysrefReq   (sysrefReq),
  .done        (done),
  .tapOut      (tapOut),
  .resultTap   (resultTap),
  .failFlag    (failFlag)
);

// File: tb/tb_sysref_delay_cal.sv
`timescale 1ns/1ps
module tb_sysref_delay_cal;

  localparam int TAP_W       = 5;
  localparam int NUM_TAPS    = 32;
  localparam int SETTLE_W    = 8;
  localparam int CAPT_CYCLES = 4;

  logic                clk = 1'b0;
  logic                rstN = 1'b0;
  logic                startReq = 1'b0;
  logic [SETTLE_W-1:0] settleCycles = '0;
  logic                dirtyIn = 1'b1;
  logic [TAP_W-1:0]    tapOut;
  logic                sysrefReq, flagClr, done, failFlag;
  logic [TAP_W-1:0]    resultTap;

  int checks = 0;
  int errors = 0;

  logic [NUM_TAPS-1:0] cleanMask = '0;
  int reqCount = 0;
  int expIdx = 0;
  int seqErr = 0;

  always #2.5 clk = ~clk;

  sysref_delay_cal #(
    .TAP_W(TAP_W), .NUM_TAPS(NUM_TAPS),
    .SETTLE_W(SETTLE_W), .CAPT_CYCLES(CAPT_CYCLES)
  ) dut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .settleCycles(settleCycles),
    .dirtyIn(dirtyIn), .tapOut(tapOut), .sysrefReq(sysrefReq), .flagClr(flagClr),
    .done(done), .resultTap(resultTap), .failFlag(failFlag)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // converter model: junk (dirty) except in the one sampling cycle (R4)
  initial begin
    forever begin
      @(negedge clk);
      if (sysrefReq) begin
        int seenTap;
        seenTap = int'(tapOut);
        if (!flagClr || seenTap != expIdx) seqErr++;
        reqCount++;
        expIdx++;
        repeat (CAPT_CYCLES) @(negedge clk);
        if (int'(tapOut) != seenTap) seqErr++;
        dirtyIn = ~cleanMask[tapOut];
        @(negedge clk);
        dirtyIn = 1'b1;
      end
    end
  end

  function automatic void model(input logic [NUM_TAPS-1:0] m, input int prevTap,
                                output int expTap, output bit expFail);
    int bestS = 0, bestL = 0, curS = 0, curL = 0;
    for (int i = 0; i < NUM_TAPS; i++) begin
      if (m[i]) begin
        if (curL == 0) curS = i;
        curL++;
        if (curL > bestL) begin bestL = curL; bestS = curS; end
      end else curL = 0;
    end
    expFail = (bestL == 0);
    expTap  = expFail ? prevTap : (bestS + bestS + bestL - 1) / 2;
  endfunction

  // runs one sweep and checks result, sequence, duration and done shape
  task automatic sweep(input logic [NUM_TAPS-1:0] m, input int settle,
                       input bit pokeStart, input string req);
    int prevTap, expTap, cyc;
    bit expFail;
    prevTap = int'(tapOut);
    model(m, prevTap, expTap, expFail);
    cleanMask = m;
    settleCycles = SETTLE_W'(settle);
    reqCount = 0; expIdx = 0; seqErr = 0;
    @(negedge clk);
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    cyc = 1;
    while (!done && cyc < 5000) begin
      @(negedge clk);
      cyc++;
      if (pokeStart && cyc == 40) startReq = 1'b1;
      if (pokeStart && cyc == 41) startReq = 1'b0;
    end
    check(cyc == NUM_TAPS * (settle + 2 + CAPT_CYCLES) + 2, {req, " R8 done cycle"},
          cyc, NUM_TAPS * (settle + 2 + CAPT_CYCLES) + 2);
    check(int'(resultTap) == expTap, {req, " R5 resultTap"}, int'(resultTap), expTap);
    check(failFlag == expFail, {req, " R6 failFlag"}, int'(failFlag), int'(expFail));
    check(int'(tapOut) == expTap, {req, " R7 tapOut at done"}, int'(tapOut), expTap);
    check(reqCount == NUM_TAPS && seqErr == 0, {req, " R2 tap order"}, reqCount * 100 + seqErr,
          NUM_TAPS * 100);
    @(negedge clk);
    check(!done, {req, " R8 done one cycle"}, int'(done), 0);
    repeat (10) @(negedge clk);
    check(int'(resultTap) == expTap && int'(tapOut) == expTap && failFlag == expFail,
          {req, " R8 result held"}, int'(resultTap), expTap);
  endtask

  task automatic testReset();
    check(tapOut == 0 && resultTap == 0 && !failFlag && !done && !sysrefReq && !flagClr,
          "R1 reset state", int'(tapOut) + int'(resultTap) + int'(failFlag) + int'(done), 0);
  endtask

  function automatic logic [NUM_TAPS-1:0] window(input int lo, input int hi);
    logic [NUM_TAPS-1:0] w = '0;
    for (int i = lo; i <= hi; i++) w[i] = 1'b1;
    return w;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    testReset();
    sweep(window(10, 20), 3, 1'b0, "single window R5");
    sweep(window(2, 5) | window(20, 27), 3, 1'b0, "two windows R5");
    sweep(window(3, 6) | window(12, 15), 0, 1'b0, "tie earliest R5 R3");
    sweep(window(8, 11), 5, 1'b0, "even run floor R5 R4");
    sweep('0, 2, 1'b0, "all dirty R6");
    sweep('1, 1, 1'b0, "all clean R10");
    sweep(window(0, 0) | window(30, 31), 2, 1'b1, "start ignored R9");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule